// File: doc/BRIEF.md
# Six-Entry Dual-Clock FIFO

This block moves data words from one clock domain to another through a queue of six entries. The write side and the read side each have their own clock and their own synchronous reset, and neither clock bears any fixed relation to the other. The writer presents a word with a write enable and is held off by a full flag. The reader takes words with a read enable and is held off by an empty flag. Each side also reports how many words it believes the queue holds.

Each side keeps its position as a plain binary counter that runs over twelve values, twice the depth. That value modulo six addresses the storage array. A second copy of each position is kept in a twelve-state cyclic code in which every step changes exactly one bit, including the step from the last value back to the first. Only this coded copy is passed to the other domain, through a chain of synchronizing flip-flops. Flags and counts are computed from the decoded copy. Because that copy lags, they err on the safe side.

Top module: `async_fifo6`

## Requirements
- R1: While both resets are high, and on the first cycle after each is released, rd_empty is 1, wr_full is 0, and wr_count and rd_count are 0.
- R2: Words leave in the order they were accepted. A read is accepted on the rclk edge where rd_en is 1 and rd_empty is 0, and rd_data shows the word from that same edge onward.
- R3: After six accepted writes with no reads, wr_full is 1 and wr_count is 6 right after the sixth accepting wclk edge.
- R4: A write presented while wr_full is 1 is dropped. The write position does not move, the stored words are not touched, and the six earlier words read back unchanged.
- R5: A read presented while rd_empty is 1 is dropped. rd_data keeps its last value, the read position does not move, and the next word written is the next word read.
- R6: The crossing code for position k = 0..11 is 0000, 0001, 0011, 0111, 0101, 0100, 1100, 1101, 1111, 1011, 1001, 1000, and then back to 0000. Each step of the registered code changes at most one bit, and the storage slot is k modulo 6. Data stays correct across many wraps of the twelve positions.
- R7: wr_count is the write position minus the synchronized read position, modulo 12. rd_count is the synchronized write position minus the read position, modulo 12. Neither ever exceeds 6, and once both sides have been idle for a few cycles, both equal the true number of words held.
- R8: Flags are never released early. After a single write into an empty queue, rd_empty stays 1 through the first rclk edge after the write and falls within four rclk cycles. Whenever rd_empty is 0, at least one unread word is really held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Write-side synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| wr_full | output | 1 | Queue full as seen from the write side |
| wr_count | output | 3 | Occupancy as seen from the write side (0..6) |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Read-side synchronous reset, active high |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word taken by the last accepted read (registered) |
| rd_empty | output | 1 | Queue empty as seen from the read side |
| rd_count | output | 3 | Occupancy as seen from the read side (0..6) |

## Verification
A directed fill to six, followed by blocked writes and a full drain, separates a correct full boundary from an off-by-one and shows that blocked writes leave the stored words intact. Reads attempted on an empty queue, followed by a single write, show whether a blocked read moves the read position, and the latency of that single word shows whether empty is released before the synchronizers could have seen the write. Two random phases run with unrelated clock periods, one write-heavy so the queue sits near full and one read-heavy so it sits near empty. Across many wraps of the twelve positions, they catch errors in the coding, the decoding and the modulo-six addressing as misordered or corrupted data. Quiet periods between phases let both counts be compared with the model.

// File: rtl/fifo6_pkg.sv
`timescale 1ns/100ps
package fifo6_pkg;

  localparam int DEPTH      = 6;
  localparam int PTR_STATES = 2 * DEPTH;
  localparam int PTR_W      = $clog2(PTR_STATES);
  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int CNT_W      = $clog2(DEPTH + 1);

  typedef logic [PTR_W-1:0] ptr_t;

  // six-step single-bit-change ring over three bits
  function automatic logic [2:0] ring6(input logic [2:0] idx);
    logic [2:0] r;
    case (idx)
      3'd0:    r = 3'b000;
      3'd1:    r = 3'b001;
      3'd2:    r = 3'b011;
      3'd3:    r = 3'b111;
      3'd4:    r = 3'b101;
      3'd5:    r = 3'b100;
      default: r = 3'b000;
    endcase
    return r;
  endfunction

  // first half walks the ring forward, second half walks it backward
  function automatic ptr_t ptr_encode(input ptr_t b);
    ptr_t c;
    if (b < ptr_t'(DEPTH))
      c = {1'b0, ring6(b[2:0])};
    else
      c = {1'b1, ring6(3'(ptr_t'(PTR_STATES - 1) - b))};
    return c;
  endfunction

  function automatic ptr_t ptr_decode(input ptr_t c);
    ptr_t b;
    b = '0;
    for (int i = 0; i < PTR_STATES; i++) begin
      if (ptr_encode(ptr_t'(i)) == c) b = ptr_t'(i);
    end
    return b;
  endfunction

  function automatic ptr_t ptr_inc(input ptr_t b);
    return (b == ptr_t'(PTR_STATES - 1)) ? '0 : b + ptr_t'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_addr(input ptr_t b);
    return (b >= ptr_t'(DEPTH)) ? ADDR_W'(b - ptr_t'(DEPTH)) : ADDR_W'(b);
  endfunction

  // (a - b) modulo PTR_STATES
  function automatic ptr_t ptr_dist(input ptr_t a, input ptr_t b);
    return (a >= b) ? (a - b) : (a + ptr_t'(PTR_STATES) - b);
  endfunction

endpackage

// File: rtl/fifo6_sync.sv
`timescale 1ns/100ps
module fifo6_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/fifo6_mem.sv
`timescale 1ns/100ps
module fifo6_mem
  import fifo6_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= ram[raddr];
  end

endmodule

// File: rtl/fifo6_wr_side.sv
`timescale 1ns/100ps
module fifo6_wr_side
  import fifo6_pkg::*;
(
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_en,
  input  ptr_t              rcode_sync,
  output logic              wr_full,
  output logic [CNT_W-1:0]  wr_count,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output ptr_t              wcode
);

  ptr_t wbin_q, wbin_nxt, rbin_seen, occ;
  logic accept;

  assign rbin_seen = ptr_decode(rcode_sync);
  assign occ       = ptr_dist(wbin_q, rbin_seen);
  assign wr_full   = (occ == ptr_t'(DEPTH));
  assign wr_count  = CNT_W'(occ);
  assign accept    = wr_en & ~wr_full;
  assign wbin_nxt  = accept ? ptr_inc(wbin_q) : wbin_q;
  assign mem_we    = accept;
  assign mem_waddr = ptr_addr(wbin_q);

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin_q <= '0;
      wcode  <= '0;
    end else begin
      wbin_q <= wbin_nxt;
      wcode  <= ptr_encode(wbin_nxt);
    end
  end

endmodule

// File: rtl/fifo6_rd_side.sv
`timescale 1ns/100ps
module fifo6_rd_side
  import fifo6_pkg::*;
(
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_en,
  input  ptr_t              wcode_sync,
  output logic              rd_empty,
  output logic [CNT_W-1:0]  rd_count,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output ptr_t              rcode
);

  ptr_t rbin_q, rbin_nxt, wbin_seen, occ;
  logic accept;

  assign wbin_seen = ptr_decode(wcode_sync);
  assign occ       = ptr_dist(wbin_seen, rbin_q);
  assign rd_empty  = (occ == '0);
  assign rd_count  = CNT_W'(occ);
  assign accept    = rd_en & ~rd_empty;
  assign rbin_nxt  = accept ? ptr_inc(rbin_q) : rbin_q;
  assign mem_re    = accept;
  assign mem_raddr = ptr_addr(rbin_q);

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin_q <= '0;
      rcode  <= '0;
    end else begin
      rbin_q <= rbin_nxt;
      rcode  <= ptr_encode(rbin_nxt);
    end
  end

endmodule

// File: rtl/async_fifo6.sv
`timescale 1ns/100ps
module async_fifo6
  import fifo6_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic [CNT_W-1:0]  wr_count,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic [CNT_W-1:0]  rd_count
);

  ptr_t wcode, rcode, wcode_sync, rcode_sync;
  logic mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;

  fifo6_wr_side u_wr (
    .wclk       (wclk),
    .wrst       (wrst),
    .wr_en      (wr_en),
    .rcode_sync (rcode_sync),
    .wr_full    (wr_full),
    .wr_count   (wr_count),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .wcode      (wcode)
  );

  fifo6_rd_side u_rd (
    .rclk       (rclk),
    .rrst       (rrst),
    .rd_en      (rd_en),
    .wcode_sync (wcode_sync),
    .rd_empty   (rd_empty),
    .rd_count   (rd_count),
    .mem_re     (mem_re),
    .mem_raddr  (mem_raddr),
    .rcode      (rcode)
  );

  fifo6_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk (rclk),
    .rst (rrst),
    .d   (wcode),
    .q   (wcode_sync)
  );

  fifo6_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk (wclk),
    .rst (wrst),
    .d   (rcode),
    .q   (rcode_sync)
  );

  fifo6_mem #(.DATA_W(DATA_W)) u_mem (
    .wclk  (wclk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .rclk  (rclk),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/fifo6_checker.sv
`timescale 1ns/100ps
module fifo6_checker
  import fifo6_pkg::*;
(
  input logic             wclk,
  input logic             wrst,
  input logic             wr_en,
  input logic             wr_full,
  input logic [CNT_W-1:0] wr_count,
  input ptr_t             wcode,
  input logic             rclk,
  input logic             rrst,
  input logic             rd_en,
  input logic             rd_empty,
  input logic [CNT_W-1:0] rd_count,
  input ptr_t             rcode
);

  // R1: empty on the first read-side cycle after reset
  a_r1_empty_after_reset: assert property (@(posedge rclk) disable iff (rrst)
    $past(rrst) |-> rd_empty);

  // R1: not full on the first write-side cycle after reset
  a_r1_not_full_after_reset: assert property (@(posedge wclk) disable iff (wrst)
    $past(wrst) |-> !wr_full);

  // R4: a blocked write leaves the crossing write code unchanged
  a_r4_full_write_dropped: assert property (@(posedge wclk) disable iff (wrst)
    (wr_full && wr_en) |=> $stable(wcode));

  // R5: a blocked read leaves the crossing read code unchanged
  a_r5_empty_read_dropped: assert property (@(posedge rclk) disable iff (rrst)
    (rd_empty && rd_en) |=> $stable(rcode));

  // R6: write code changes at most one bit per write-clock step
  a_r6_wcode_one_bit: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wcode ^ $past(wcode)) <= 1);

  // R6: read code changes at most one bit per read-clock step
  a_r6_rcode_one_bit: assert property (@(posedge rclk) disable iff (rrst)
    $countones(rcode ^ $past(rcode)) <= 1);

  // R7: occupancy never exceeds the depth on either side
  a_r7_wr_count_bound: assert property (@(posedge wclk) disable iff (wrst)
    wr_count <= CNT_W'(DEPTH));

  a_r7_rd_count_bound: assert property (@(posedge rclk) disable iff (rrst)
    rd_count <= CNT_W'(DEPTH));

endmodule

bind async_fifo6 fifo6_checker u_chk (
  .wclk     (wclk),
  .wrst     (wrst),
  .wr_en    (wr_en),
  .wr_full  (wr_full),
  .wr_count (wr_count),
  .wcode    (wcode),
  .rclk     (rclk),
  .rrst     (rrst),
  .rd_en    (rd_en),
  .rd_empty (rd_empty),
  .rd_count (rd_count),
  .rcode    (rcode)
);

// File: tb/tb_async_fifo6.sv
`timescale 1ns/100ps
module tb_async_fifo6;

  localparam int DW = 16;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wrst = 1'b1, rrst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_full, rd_empty;
  logic [2:0]    wr_count, rd_count;

  int n_checks = 0;
  int n_err    = 0;
  int n_xfer   = 0;
  logic [DW-1:0] exp_q [$];
  bit rd_pend = 1'b0;

  // 250 MHz write clock, unrelated read clock
  always #2.0 wclk = ~wclk;
  always #3.3 rclk = ~rclk;

  async_fifo6 #(.DATA_W(DW)) dut (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_full(wr_full), .wr_count(wr_count),
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_count(rd_count)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the model and compares each accepted read
  always begin
    @(negedge rclk);
    #0.5;
    if (rd_pend) begin
      if (exp_q.size() > 0) begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R2 R6 read order", 32'(rd_data), 32'(e));
        n_xfer++;
      end else begin
        check(1'b0, "R8 read with empty model", 32'(rd_data), 0);
      end
    end
    rd_pend = rd_en && !rd_empty && !rrst;
    if (rd_pend)
      check(exp_q.size() > 0, "R8 empty released early",
            32'(exp_q.size()), 1);
  end

  task automatic write_word(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en   = 1'b1;
    wr_data = d;
    if (!wr_full) exp_q.push_back(d);
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic read_word();
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge wclk);
    repeat (n) @(negedge rclk);
  endtask

  task automatic rand_writes(input int cycles, input int pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge wclk);
      wr_en   = ($urandom % 100) < pct;
      wr_data = DW'($urandom);
      if (wr_en && !wr_full) exp_q.push_back(wr_data);
    end
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rand_reads(input int cycles, input int pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge rclk);
      rd_en = ($urandom % 100) < pct;
    end
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() > 0; i++) read_word();
    idle(8);
  endtask

  task automatic quiet_counts(input string tag);
    idle(8);
    @(negedge wclk);
    check(wr_count == 3'(exp_q.size()), tag, 32'(wr_count), 32'(exp_q.size()));
    @(negedge rclk);
    check(rd_count == 3'(exp_q.size()), tag, 32'(rd_count), 32'(exp_q.size()));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    #400000;
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    logic [DW-1:0] held;

    // R1: reset state
    repeat (6) @(negedge rclk);
    check(rd_empty == 1'b1, "R1 empty in reset", 32'(rd_empty), 1);
    check(wr_full == 1'b0, "R1 full in reset", 32'(wr_full), 0);
    @(negedge wclk); wrst = 1'b0;
    @(negedge rclk); rrst = 1'b0;
    @(negedge wclk);
    check(wr_count == 3'd0 && !wr_full, "R1 write side after reset", 32'(wr_count), 0);
    @(negedge rclk);
    check(rd_count == 3'd0 && rd_empty, "R1 read side after reset", 32'(rd_count), 0);

    // R3: fill to six
    for (int i = 0; i < 6; i++) write_word(DW'(16'hA000 + i));
    check(wr_full == 1'b1, "R3 full after six writes", 32'(wr_full), 1);
    check(wr_count == 3'd6, "R3 count after six writes", 32'(wr_count), 6);

    // R4: writes while full are dropped
    for (int i = 0; i < 3; i++) write_word(DW'(16'hBEE0 + i));
    check(wr_count == 3'd6, "R4 count after blocked writes", 32'(wr_count), 6);
    check(exp_q.size() == 6, "R4 model holds six", 32'(exp_q.size()), 6);
    quiet_counts("R7 counts when full");

    // R2 R4: drain in order, blocked words never appear
    for (int i = 0; i < 6; i++) read_word();
    idle(8);
    check(rd_empty == 1'b1, "R2 empty after drain", 32'(rd_empty), 1);
    quiet_counts("R7 counts after drain");

    // R5: reads while empty are dropped
    @(negedge rclk);
    held = rd_data;
    for (int i = 0; i < 3; i++) read_word();
    @(negedge rclk);
    check(rd_data == held, "R5 rd_data held", 32'(rd_data), 32'(held));
    check(rd_count == 3'd0, "R5 count stays zero", 32'(rd_count), 0);

    // R8: single write into empty queue, empty released late but not early
    @(negedge wclk);
    wr_en = 1'b1; wr_data = 16'h5A5A; exp_q.push_back(16'h5A5A);
    @(negedge wclk);
    wr_en = 1'b0;
    check(rd_empty == 1'b1, "R8 empty right after write", 32'(rd_empty), 1);
    @(posedge rclk);
    @(negedge rclk);
    check(rd_empty == 1'b1, "R8 empty after one rclk edge", 32'(rd_empty), 1);
    repeat (3) @(negedge rclk);
    check(rd_empty == 1'b0, "R8 empty released", 32'(rd_empty), 0);
    read_word();  // R5: this must return 5A5A
    idle(8);

    // write-heavy random traffic: queue sits near full
    fork
      rand_writes(3000, 80);
      rand_reads(1800, 35);
    join
    quiet_counts("R7 counts after write-heavy phase");
    drain();

    // read-heavy random traffic: queue sits near empty
    fork
      rand_writes(3000, 30);
      rand_reads(1800, 85);
    join
    drain();
    quiet_counts("R7 counts after read-heavy phase");
    check(exp_q.size() == 0, "R2 model empty at end", 32'(exp_q.size()), 0);
    check(n_xfer >= 48, "R6 many pointer wraps", 32'(n_xfer), 48);

    summary();
  end

endmodule